// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block holds the hazard control of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back), together with a compact model of the four stage registers that lie between those stages. Each stage register carries an instruction's control bits, its two source register numbers, its destination register number and an identifying tag. The block decides, every cycle, whether the program counter and the fetch/decode register advance, whether a bubble goes into the decode/execute register, and whether the two youngest stage registers are squashed.

Two hazards are handled. A load in execute whose destination matches a source of the instruction in decode cannot be covered by forwarding, so the front of the pipe freezes for one cycle and a bubble enters execute. Conditional branches have no prediction and resolve in execute; when one resolves taken, the program counter is redirected and both younger stage registers become bubbles on the same edge. If both happen in one cycle the squash wins, since the stalled instruction is on the wrong path.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While reset is low the program counter is zero and every stage register holds a bubble, so `ex_tag`, `wb_tag`, `wb_ctrl` and `wb_dst` read zero.
- R2: With no hazard the program counter rises by 4 each cycle, and an instruction fetched in cycle c appears at the write-back outputs after the fourth rising edge, one instruction per cycle in fetch order.
- R3: When the execute instruction has its memory-read bit (control bit 2) set and its destination equals the decode instruction's first source, `pc_we` and `ifid_we` are low and `idex_bubble` is high for exactly one cycle; the program counter and decode instruction hold, and one bubble follows the load down the pipe.
- R4: The same one-cycle stall occurs when the load's destination equals the decode instruction's second source.
- R5: A producer without the memory-read bit, or a load whose destination matches neither decode source, causes no stall.
- R6: When `br_taken` is high, the program counter takes `br_target` on the next edge, `ifid_flush` and `idex_flush` are high, and the two instructions younger than the one in execute never reach write-back.
- R7: When `br_taken` and a load-use hazard coincide, the squash wins: `pc_we` is high, `idex_bubble` is low and the flush proceeds as in R6.
- R8: A bubble has all four control bits (bit 3 register write, bit 2 memory read, bit 1 memory write, bit 0 branch) clear and a tag of zero.
- R9: The control bits, destination register number and tag of an instruction reach the write-back outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_ctrl | input | 4 | Control bits of the fetched instruction |
| if_rs | input | REG_W | First source register of the fetched instruction |
| if_rt | input | REG_W | Second source register of the fetched instruction |
| if_dst | input | REG_W | Destination register of the fetched instruction |
| if_tag | input | TAG_W | Identifying tag of the fetched instruction |
| br_taken | input | 1 | Branch in execute resolved taken |
| br_target | input | PC_W | Redirect address for a taken branch |
| pc | output | PC_W | Current fetch address |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register load enable |
| idex_bubble | output | 1 | Bubble into decode/execute because of a load-use stall |
| ifid_flush | output | 1 | Squash fetch/decode register |
| idex_flush | output | 1 | Squash decode/execute register |
| ex_tag | output | TAG_W | Tag of the instruction in execute |
| wb_ctrl | output | 4 | Control bits of the instruction in write-back |
| wb_dst | output | REG_W | Destination register of the instruction in write-back |
| wb_tag | output | TAG_W | Tag of the instruction in write-back |

## Verification
The assertions take for granted that real instructions never carry a zero tag, so a zero tag in write-back marks a bubble, and that `br_taken` is raised only for the one cycle when the resolving instruction sits in execute. The stimulus keeps to this by tagging every program slot with its index plus one and deriving `br_taken` combinationally from `ex_tag` matching a chosen tag, which drops as soon as the squash empties execute.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int CTRL_W    = 4;
  localparam int CB_REG_WR = 3;
  localparam int CB_MEM_RD = 2;
  localparam int CB_MEM_WR = 1;
  localparam int CB_BRANCH = 0;
  localparam int NSTG      = 4;
endpackage

// File: rtl/hz_detect.sv
module hz_detect #(
  parameter int REG_W = 5
) (
  input  logic             ex_mem_rd,
  input  logic [REG_W-1:0] ex_dst,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             br_taken,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_bubble,
  output logic             flush
);
  logic load_use;
  logic stall;

  always_comb begin
    load_use    = ex_mem_rd && ((ex_dst == id_rs) || (ex_dst == id_rt));
    // squash outranks the stall: the stalled instruction is on the wrong path
    stall       = load_use && !br_taken;
    flush       = br_taken;
    pc_we       = !stall;
    ifid_we     = !stall;
    idex_bubble = stall;
  end
endmodule

// File: rtl/hz_pc.sv
module hz_pc #(
  parameter int PC_W    = 16,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  logic [PC_W-1:0] pc_nxt;

  always_comb begin
    if (redirect) pc_nxt = target;
    else          pc_nxt = pc + PC_W'(PC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pc <= '0;
    else if (en) pc <= pc_nxt;
  end
endmodule

// File: rtl/hz_stage.sv
module hz_stage #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    if (clr)     q_nxt = '0;
    else if (en) q_nxt = d;
    else         q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hz_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int REG_W   = 5,
  parameter int TAG_W   = 8,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] if_ctrl,
  input  logic [REG_W-1:0]  if_rs,
  input  logic [REG_W-1:0]  if_rt,
  input  logic [REG_W-1:0]  if_dst,
  input  logic [TAG_W-1:0]  if_tag,
  input  logic              br_taken,
  input  logic [PC_W-1:0]   br_target,
  output logic [PC_W-1:0]   pc,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble,
  output logic              ifid_flush,
  output logic              idex_flush,
  output logic [TAG_W-1:0]  ex_tag,
  output logic [CTRL_W-1:0] wb_ctrl,
  output logic [REG_W-1:0]  wb_dst,
  output logic [TAG_W-1:0]  wb_tag
);
  localparam int IW     = CTRL_W + 3*REG_W + TAG_W;
  localparam int TAG_LO = 0;
  localparam int DST_LO = TAG_W;
  localparam int RT_LO  = TAG_W + REG_W;
  localparam int RS_LO  = TAG_W + 2*REG_W;
  localparam int CTL_LO = TAG_W + 3*REG_W;

  logic [IW-1:0] stg_d [NSTG];
  logic [IW-1:0] stg_q [NSTG];
  logic          stg_en  [NSTG];
  logic          stg_clr [NSTG];
  logic          flush_w;

  // stage 0: fetch/decode, 1: decode/execute, 2: execute/memory, 3: memory/write-back
  always_comb begin
    stg_d[0]   = {if_ctrl, if_rs, if_rt, if_dst, if_tag};
    stg_en[0]  = ifid_we;
    stg_clr[0] = flush_w;
    stg_en[1]  = 1'b1;
    stg_clr[1] = flush_w || idex_bubble;
    for (int i = 1; i < NSTG; i++) stg_d[i] = stg_q[i-1];
    for (int i = 2; i < NSTG; i++) begin
      stg_en[i]  = 1'b1;
      stg_clr[i] = 1'b0;
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    hz_stage #(.W(IW)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (stg_en[g]),
      .clr  (stg_clr[g]),
      .d    (stg_d[g]),
      .q    (stg_q[g])
    );
  end

  hz_detect #(.REG_W(REG_W)) u_detect (
    .ex_mem_rd  (stg_q[1][CTL_LO + CB_MEM_RD]),
    .ex_dst     (stg_q[1][DST_LO +: REG_W]),
    .id_rs      (stg_q[0][RS_LO +: REG_W]),
    .id_rt      (stg_q[0][RT_LO +: REG_W]),
    .br_taken   (br_taken),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .idex_bubble(idex_bubble),
    .flush      (flush_w)
  );

  hz_pc #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (pc_we),
    .redirect(br_taken),
    .target  (br_target),
    .pc      (pc)
  );

  always_comb begin
    ifid_flush = flush_w;
    idex_flush = flush_w;
    ex_tag     = stg_q[1][TAG_LO +: TAG_W];
    wb_ctrl    = stg_q[3][CTL_LO +: CTRL_W];
    wb_dst     = stg_q[3][DST_LO +: REG_W];
    wb_tag     = stg_q[3][TAG_LO +: TAG_W];
  end
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int PC_W    = 16,
  parameter int TAG_W   = 8,
  parameter int PC_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_taken,
  input logic [PC_W-1:0]  br_target,
  input logic [PC_W-1:0]  pc,
  input logic             pc_we,
  input logic             ifid_we,
  input logic             idex_bubble,
  input logic             ifid_flush,
  input logic             idex_flush,
  input logic [3:0]       wb_ctrl,
  input logic [TAG_W-1:0] wb_tag
);
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !br_taken) |=> (pc == $past(pc) + PC_W'(PC_STEP)));

  p_stall_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_we && !ifid_we && !ifid_flush));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> (pc == $past(pc)));

  p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (pc == $past(br_target)));

  p_flush_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (ifid_flush && idex_flush && pc_we && !idex_bubble));

  p_bubble_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_tag == '0) |-> (wb_ctrl == 4'b0000));
endmodule

bind pipe_hazard_unit hz_checker #(.PC_W(PC_W), .TAG_W(TAG_W), .PC_STEP(PC_STEP)) u_hz_checker (.*);

// File: tb/test_pipe_hazard_unit.sv
module test_pipe_hazard_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 16;
  localparam int REG_W = 5;
  localparam int TAG_W = 8;
  localparam int IW    = 4 + 3*REG_W + TAG_W;
  localparam int NCAP  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        if_ctrl;
  logic [REG_W-1:0]  if_rs, if_rt, if_dst;
  logic [TAG_W-1:0]  if_tag;
  logic              br_taken;
  logic [PC_W-1:0]   br_target;
  logic [PC_W-1:0]   pc;
  logic              pc_we, ifid_we, idex_bubble, ifid_flush, idex_flush;
  logic [TAG_W-1:0]  ex_tag, wb_tag;
  logic [3:0]        wb_ctrl;
  logic [REG_W-1:0]  wb_dst;

  logic [IW-1:0]     prog [32];
  logic [TAG_W-1:0]  taken_tag;
  logic              taken_en;

  int total = 0;
  int bad   = 0;

  logic [TAG_W-1:0] cap_tag  [NCAP];
  logic [3:0]       cap_ctrl [NCAP];
  logic [REG_W-1:0] cap_dst  [NCAP];
  logic             cap_stl  [NCAP];
  logic             cap_fl   [NCAP];
  logic [PC_W-1:0]  cap_pc   [NCAP];
  logic [TAG_W-1:0] exp_seq  [NCAP];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    {if_ctrl, if_rs, if_rt, if_dst, if_tag} = prog[pc[6:2]];
    br_taken  = taken_en && (ex_tag == taken_tag);
    br_target = 16'h0040;
  end

  pipe_hazard_unit i_pipe_hazard_unit (
    .clk(clk), .rst_n(rst_n),
    .if_ctrl(if_ctrl), .if_rs(if_rs), .if_rt(if_rt), .if_dst(if_dst), .if_tag(if_tag),
    .br_taken(br_taken), .br_target(br_target),
    .pc(pc), .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush), .idex_flush(idex_flush),
    .ex_tag(ex_tag), .wb_ctrl(wb_ctrl), .wb_dst(wb_dst), .wb_tag(wb_tag)
  );

  function automatic logic [IW-1:0] mk(logic [3:0] c, logic [REG_W-1:0] rs,
                                       logic [REG_W-1:0] rt, logic [REG_W-1:0] dst,
                                       logic [TAG_W-1:0] tag);
    return {c, rs, rt, dst, tag};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // every slot is an ALU op writing r3 from r1,r2; tag = slot index + 1
  task automatic load_default();
    for (int i = 0; i < 32; i++) prog[i] = mk(4'b1000, 5'd1, 5'd2, 5'd3, TAG_W'(i + 1));
    taken_en  = 1'b0;
    taken_tag = '1;
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pc == '0,      "R1 pc", int'(pc), 0);
    chk(wb_tag == '0 && ex_tag == '0, "R1 tags", int'(wb_tag) + int'(ex_tag), 0);
    chk(wb_ctrl == '0 && wb_dst == '0, "R1 wb ctrl/dst", int'(wb_ctrl), 0);
    rst_n = 1'b1;
  endtask

  task automatic capture();
    for (int k = 0; k < NCAP; k++) begin
      @(posedge clk);
      @(negedge clk);
      cap_tag[k]  = wb_tag;
      cap_ctrl[k] = wb_ctrl;
      cap_dst[k]  = wb_dst;
      cap_stl[k]  = !pc_we && !ifid_we && idex_bubble;
      cap_fl[k]   = ifid_flush && idex_flush;
      cap_pc[k]   = pc;
    end
  endtask

  task automatic check_seq(input string req);
    int first_bad = -1;
    for (int k = 0; k < NCAP; k++)
      if (first_bad < 0 && cap_tag[k] != exp_seq[k]) first_bad = k;
    if (first_bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(cap_tag[first_bad]), int'(exp_seq[first_bad]));
    first_bad = -1;
    for (int k = 0; k < NCAP; k++)
      if (first_bad < 0 && cap_tag[k] == '0 && cap_ctrl[k] != '0) first_bad = k;
    chk(first_bad < 0, "R8 bubble control bits",
        first_bad < 0 ? 0 : int'(cap_ctrl[first_bad]), 0);
  endtask

  function automatic int stall_count();
    int n = 0;
    for (int k = 0; k < NCAP; k++) if (cap_stl[k]) n++;
    return n;
  endfunction

  task automatic t_stream();
    load_default();
    reset_dut();
    capture();
    exp_seq = '{0,0,0,1,2,3,4,5,6,7,8,9};
    check_seq("R2 in-order stream");
    chk(cap_pc[3] == 16'd16, "R2 pc step", int'(cap_pc[3]), 16);
    chk(stall_count() == 0, "R2 no stall", stall_count(), 0);
  endtask

  task automatic t_load_use_rs();
    load_default();
    prog[0] = mk(4'b1100, 5'd1, 5'd2, 5'd5, 8'd1);
    prog[1] = mk(4'b1000, 5'd5, 5'd2, 5'd3, 8'd2);
    reset_dut();
    capture();
    exp_seq = '{0,0,0,1,0,2,3,4,5,6,7,8};
    check_seq("R3 load-use rs sequence");
    chk(stall_count() == 1, "R3 one stall cycle", stall_count(), 1);
    chk(cap_stl[1], "R3 stall cycle position", int'(cap_stl[1]), 1);
    chk(cap_pc[1] == 16'd8 && cap_pc[2] == 16'd8, "R3 pc held", int'(cap_pc[2]), 8);
    chk(cap_ctrl[3] == 4'b1100 && cap_dst[3] == 5'd5, "R9 load fields at write-back",
        int'({cap_ctrl[3], cap_dst[3]}), int'({4'b1100, 5'd5}));
  endtask

  task automatic t_load_use_rt();
    load_default();
    prog[0] = mk(4'b1100, 5'd1, 5'd2, 5'd5, 8'd1);
    prog[1] = mk(4'b1000, 5'd1, 5'd5, 5'd3, 8'd2);
    reset_dut();
    capture();
    exp_seq = '{0,0,0,1,0,2,3,4,5,6,7,8};
    check_seq("R4 load-use rt sequence");
    chk(stall_count() == 1, "R4 one stall cycle", stall_count(), 1);
  endtask

  task automatic t_no_stall();
    load_default();
    prog[0] = mk(4'b1100, 5'd1, 5'd2, 5'd5, 8'd1);
    reset_dut();
    capture();
    exp_seq = '{0,0,0,1,2,3,4,5,6,7,8,9};
    check_seq("R5 independent load");
    chk(stall_count() == 0, "R5 independent load stall", stall_count(), 0);
    load_default();
    prog[0] = mk(4'b1000, 5'd1, 5'd2, 5'd5, 8'd1);
    prog[1] = mk(4'b1000, 5'd5, 5'd5, 5'd3, 8'd2);
    reset_dut();
    capture();
    check_seq("R5 ALU producer");
    chk(stall_count() == 0, "R5 ALU producer stall", stall_count(), 0);
    chk(cap_dst[3] == 5'd5 && cap_ctrl[3] == 4'b1000, "R9 ALU fields at write-back",
        int'(cap_dst[3]), 5);
  endtask

  task automatic t_branch();
    load_default();
    prog[0] = mk(4'b0001, 5'd1, 5'd2, 5'd0, 8'd1);
    taken_tag = 8'd1;
    taken_en  = 1'b1;
    reset_dut();
    capture();
    exp_seq = '{0,0,0,1,0,0,17,18,19,20,21,22};
    check_seq("R6 taken branch squash");
    chk(cap_fl[1], "R6 flush raised", int'(cap_fl[1]), 1);
    chk(cap_pc[2] == 16'h0040, "R6 pc redirect", int'(cap_pc[2]), 64);
  endtask

  task automatic t_conflict();
    load_default();
    prog[0] = mk(4'b1100, 5'd1, 5'd2, 5'd5, 8'd1);
    prog[1] = mk(4'b1000, 5'd5, 5'd2, 5'd3, 8'd2);
    taken_tag = 8'd1;
    taken_en  = 1'b1;
    reset_dut();
    capture();
    exp_seq = '{0,0,0,1,0,0,17,18,19,20,21,22};
    check_seq("R7 squash over stall sequence");
    chk(stall_count() == 0, "R7 stall suppressed", stall_count(), 0);
    chk(cap_fl[1] && cap_pc[2] == 16'h0040, "R7 redirect taken", int'(cap_pc[2]), 64);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    load_default();
    t_stream();
    t_load_use_rs();
    t_load_use_rt();
    t_no_stall();
    t_branch();
    t_conflict();
    reset_dut();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule